// File: doc/BRIEF.md
# Alternating-Compare PWM Timer

An 8-bit up-counting timer that produces a pulse-width-modulated waveform from two stored limits: a cycle limit and a duty limit. A single equality comparator is shared between them. After the timer is started it watches the cycle limit. When that limit is reached, the counter restarts from zero, a one-clock interrupt pulse is issued, the output goes to its active level, and the comparator switches to the duty limit. When the duty limit is reached, the output returns to its inactive level and the comparator switches back to the cycle limit. On this second match the counter keeps counting and no interrupt is raised.

Software writes the cycle limit, the duty limit and a control word. The control word holds the count-clock code, the mode, the inactive output level and the output enable. It then raises the run input. The count advances on a strobe derived from the system clock by a power-of-two divider chosen by a 3-bit code. With cycle limit N and duty limit M, where 0 <= M < N <= 255, each output period lasts N+1 count ticks and the active part lasts M+1 ticks. The duty limit may be changed on the fly. The cycle limit and the control word are frozen while the timer runs.

Top module: `alt_cmp_pwm`

## Requirements
- R1: While `run_en` is 0 (and after reset), the counter is held at 0, the comparator watches the cycle limit, `irq` is 0 and `pwm_out` sits at the inactive level.
- R2: Count ticks occur once every 2^`ctrl_clksel` system clocks (code 0 to 7 gives divide by 1 to 128), and the counter changes only on a tick.
- R3: After `run_en` rises, the first `irq` is seen (N+1)*2^code clocks later, and `pwm_out` stays inactive until then.
- R4: On a cycle-limit match the counter clears, `irq` is high for exactly one clock, and `pwm_out` becomes active. Successive `irq` pulses are (N+1)*2^code clocks apart.
- R5: On a duty-limit match `pwm_out` becomes inactive, the counter is not cleared and no `irq` is raised. The active time per period is (M+1)*2^code clocks.
- R6: `ctrl_idle_lvl` is the inactive output level, and the active level is its complement.
- R7: With `ctrl_oe` = 0, `pwm_out` is held at the inactive level while counting and `irq` still pulses.
- R8: A cycle-limit write (`period_we`) while `run_en` = 1 is ignored. The old limit stays in force, also after a later restart.
- R9: A duty-limit write (`duty_we`) is accepted while running and governs the following duty comparisons.
- R10: Control writes while `run_en` = 1 are ignored. The timer counts only when the mode field equals 2'b10. In any other mode it produces no `irq` and holds the output inactive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | Start/stop of counting (level) |
| period_we | input | 1 | Write strobe for the cycle limit |
| duty_we | input | 1 | Write strobe for the duty limit |
| wdata | input | 8 | Limit value for period_we / duty_we |
| ctrl_we | input | 1 | Write strobe for the control fields |
| ctrl_clksel | input | 3 | Count-clock code: divide by 2^code |
| ctrl_mode | input | 2 | Mode; 2'b10 selects PWM |
| ctrl_idle_lvl | input | 1 | Inactive output level |
| ctrl_oe | input | 1 | Output enable |
| pwm_out | output | 1 | PWM waveform |
| irq | output | 1 | One-clock pulse on each cycle-limit match |

## Verification
The embedded assertions check the following on every cycle: the stopped state, the counter holding between ticks, the clearing of the counter with each interrupt, the rule that the active phase can start only with an interrupt, the absence of an interrupt on a duty match, and the frozen cycle limit while running. Only the bench's scenarios can show the actual waveform timing. This covers the delay to the first match, the period and active widths across prescaler codes and limits from the boundaries, the polarity and output-enable effects, duty updates on the fly, and the dropped writes observed through the unchanged period.

// File: rtl/alt_cmp_pwm.sv
module alt_cmp_pwm #(
  parameter int W    = 8,
  parameter int SELW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run_en,
  input  logic            period_we,
  input  logic            duty_we,
  input  logic [W-1:0]    wdata,
  input  logic            ctrl_we,
  input  logic [SELW-1:0] ctrl_clksel,
  input  logic [1:0]      ctrl_mode,
  input  logic            ctrl_idle_lvl,
  input  logic            ctrl_oe,
  output logic            pwm_out,
  output logic            irq
);
  localparam int DIVW = (1 << SELW) - 1;
  localparam logic [1:0] MODE_PWM = 2'b10;

  logic [W-1:0]    period_q, duty_q, cnt;
  logic [SELW-1:0] clksel_q;
  logic [1:0]      mode_q;
  logic            idle_q, oe_q;
  logic            on_duty, act;
  logic [DIVW-1:0] div;
  logic [DIVW:0]   mask_w;
  logic            running, cnt_tick, hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= '1;
      duty_q   <= '0;
      clksel_q <= '0;
      mode_q   <= '0;
      idle_q   <= 1'b0;
      oe_q     <= 1'b0;
    end else begin
      if (period_we && !run_en) period_q <= wdata;
      if (duty_we) duty_q <= wdata;
      if (ctrl_we && !run_en) begin
        clksel_q <= ctrl_clksel;
        mode_q   <= ctrl_mode;
        idle_q   <= ctrl_idle_lvl;
        oe_q     <= ctrl_oe;
      end
    end
  end

  assign running  = run_en && (mode_q == MODE_PWM);
  assign mask_w   = ((DIVW+1)'(1) << clksel_q) - (DIVW+1)'(1);
  assign cnt_tick = running && ((div & mask_w[DIVW-1:0]) == mask_w[DIVW-1:0]);
  assign hit      = cnt == (on_duty ? duty_q : period_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div     <= '0;
      cnt     <= '0;
      on_duty <= 1'b0;
      act     <= 1'b0;
      irq     <= 1'b0;
    end else if (!running) begin
      div     <= '0;
      cnt     <= '0;
      on_duty <= 1'b0;
      act     <= 1'b0;
      irq     <= 1'b0;
    end else begin
      div <= div + 1'b1;
      irq <= 1'b0;
      if (cnt_tick) begin
        if (hit && !on_duty) begin
          cnt     <= '0;
          irq     <= 1'b1;
          act     <= 1'b1;
          on_duty <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
          if (hit) begin
            act     <= 1'b0;
            on_duty <= 1'b0;
          end
        end
      end
    end
  end

  assign pwm_out = (act && oe_q) ? ~idle_q : idle_q;

  p_off_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (cnt == '0 && !on_duty && !act && !irq));

  p_hold_between_ticks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !cnt_tick) |=> $stable(cnt));

  p_irq_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && period_q != '0) |=> !irq);

  p_clear_with_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (cnt == '0));

  p_active_starts_on_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act) |-> irq);

  p_duty_no_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_tick && on_duty) |=> !irq);

  p_period_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && period_we) |=> $stable(period_q));
endmodule

// File: tb/alt_cmp_pwm_bench.sv
module alt_cmp_pwm_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_en = 1'b0, period_we = 1'b0, duty_we = 1'b0, ctrl_we = 1'b0;
  logic [7:0] wdata = '0;
  logic [2:0] ctrl_clksel = '0;
  logic [1:0] ctrl_mode = '0;
  logic ctrl_idle_lvl = 1'b0, ctrl_oe = 1'b0;
  logic pwm_out, irq;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  alt_cmp_pwm u_alt_cmp_pwm (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .period_we(period_we),
    .duty_we(duty_we), .wdata(wdata), .ctrl_we(ctrl_we),
    .ctrl_clksel(ctrl_clksel), .ctrl_mode(ctrl_mode),
    .ctrl_idle_lvl(ctrl_idle_lvl), .ctrl_oe(ctrl_oe),
    .pwm_out(pwm_out), .irq(irq)
  );

  function automatic int exp_cycle(int n, int s);
    return (n + 1) << s;
  endfunction

  function automatic int exp_active(int m, int s, bit oe);
    return oe ? ((m + 1) << s) : 0;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_period(input int v);
    @(negedge clk); wdata = 8'(v); period_we = 1'b1;
    @(negedge clk); period_we = 1'b0;
  endtask

  task automatic write_duty(input int v);
    @(negedge clk); wdata = 8'(v); duty_we = 1'b1;
    @(negedge clk); duty_we = 1'b0;
  endtask

  task automatic write_ctrl(input int s, input int mode, input bit idle, input bit oe);
    @(negedge clk);
    ctrl_clksel = 3'(s); ctrl_mode = 2'(mode); ctrl_idle_lvl = idle; ctrl_oe = oe;
    ctrl_we = 1'b1;
    @(negedge clk); ctrl_we = 1'b0;
  endtask

  // run_en must have been raised at the current negedge
  task automatic wait_first(input bit idle, output int c, output int bad);
    c = 0; bad = 0;
    forever begin
      @(negedge clk); c++;
      if (irq || c > 40000) break;
      if (pwm_out != idle) bad++;
    end
  endtask

  task automatic wait_irq();
    int c = 0;
    do begin @(negedge clk); c++; end while (!irq && c < 40000);
  endtask

  // called at a sample where irq is 1; returns at the next irq sample
  task automatic measure(input bit idle, output int clocks, output int act, output int irqs);
    clocks = 0; act = 0; irqs = 0;
    do begin
      if (pwm_out != idle) act++;
      if (irq) irqs++;
      clocks++;
      @(negedge clk);
    end while (!irq && clocks < 40000);
  endtask

  task automatic run_case(input int n, input int m, input int s, input bit idle, input bit oe);
    int c, bad, clocks, act, irqs;
    write_period(n);
    write_duty(m);
    write_ctrl(s, 2, idle, oe);
    @(negedge clk);
    check(pwm_out == idle, "R6 idle level while stopped", pwm_out, idle);
    run_en = 1'b1;
    wait_first(idle, c, bad);
    check(c == exp_cycle(n, s), "R3 first match delay (R2 prescale)", c, exp_cycle(n, s));
    check(bad == 0, "R3 inactive before first match", bad, 0);
    check(pwm_out == (oe ? ~idle : idle), "R6 active level at match (R7)", pwm_out, oe ? ~idle : idle);
    measure(idle, clocks, act, irqs);
    check(clocks == exp_cycle(n, s), "R4 period spacing", clocks, exp_cycle(n, s));
    check(act == exp_active(m, s, oe), "R5 active width (R7 when off)", act, exp_active(m, s, oe));
    check(irqs == 1, "R4 irq one clock wide", irqs, 1);
    @(negedge clk); run_en = 1'b0;
    @(negedge clk);
    check(pwm_out == idle && !irq, "R1 stop returns to inactive", pwm_out, idle);
  endtask

  initial begin
    int c, bad, clocks, act, irqs, quiet;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(pwm_out == 1'b0 && irq == 1'b0, "R1 reset state", pwm_out, 0);

    // directed boundaries
    run_case(255, 254, 0, 1'b0, 1'b1);
    run_case(1, 0, 0, 1'b1, 1'b1);
    run_case(3, 1, 7, 1'b0, 1'b1);
    run_case(255, 0, 1, 1'b1, 1'b1);
    run_case(10, 4, 2, 1'b1, 1'b0);

    // random
    for (int i = 0; i < 12; i++) begin
      int n = 1 + int'($urandom % 255);
      int m = int'($urandom % n);
      int s = int'($urandom % 4);
      run_case(n, m, s, bit'($urandom % 2), ($urandom % 4) != 0);
    end

    // R8 / R10: writes while running are dropped
    write_period(20); write_duty(5); write_ctrl(0, 2, 1'b0, 1'b1);
    @(negedge clk); run_en = 1'b1;
    wait_first(1'b0, c, bad);
    write_period(100);
    write_ctrl(2, 2, 1'b1, 1'b0);
    wait_irq();
    measure(1'b0, clocks, act, irqs);
    check(clocks == 21, "R8 period write ignored while running", clocks, 21);
    check(act == 6, "R10 ctrl write ignored while running", act, 6);
    @(negedge clk); run_en = 1'b0;
    @(negedge clk); run_en = 1'b1;
    wait_first(1'b0, c, bad);
    check(c == 21, "R8 old period kept after restart", c, 21);

    // R9: duty rewrite on the fly
    write_duty(15);
    wait_irq();
    measure(1'b0, clocks, act, irqs);
    check(act == 16, "R9 new duty applied", act, 16);
    check(clocks == 21, "R9 period unchanged by duty write", clocks, 21);
    @(negedge clk); run_en = 1'b0;

    // R10: non-PWM mode does not count
    write_ctrl(0, 1, 1'b1, 1'b1);
    @(negedge clk); run_en = 1'b1;
    quiet = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (irq || pwm_out != 1'b1) quiet++;
    end
    check(quiet == 0, "R10 non-PWM mode idle", quiet, 0);
    @(negedge clk); run_en = 1'b0;

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    n_tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule